// File: doc/BRIEF.md
# Carrier and Sample-Phase Timing Generator

This block derives the antenna carrier for a contactless tag reader from the system clock. With the default parameters, one carrier period is 64 clocks, so an 8 MHz clock gives a 125 kHz carrier. While the antenna drivers are enabled, the block drives two complementary drive levels. Once per carrier period it raises a one-clock sample strobe for the demodulator. The strobe sits at a selectable offset from the falling edge of the primary drive level. The offset is set in steps of 1/32 of a period (11.25°, two clocks). The usable range runs from seven steps before that edge to eight steps after it.

The offset is loaded from an external evaluation result, and only during an evaluation window. The window opens at reset and again after each wake-up. It closes as soon as one code has been taken. Until the first code is loaded, the offset is one step after the edge.

A preload sequencer produces a single pulse that precharges the demodulator's hold capacitor. The pulse is 1024 clocks long. When the drivers switch on, it starts 2048 clocks later. After a reset or a wake-up, it starts 4144 clocks later.

Top module: `carrier_phase_gen`

## Requirements
- R1: While `driversOn` is high, `td1` is high when the carrier count is 0 to 31 and low when it is 32 to 63. The count is 0 at reset and advances by one each clock, so after the n-th clock edge following reset release it equals n mod 64. `td2` is the complement of `td1`.
- R2: While `driversOn` is low, `td1`, `td2` and `sampleStrobe` are all low.
- R3: While the drivers are on, `sampleStrobe` is high for exactly one clock per carrier period, at carrier count (32 + 2·s) mod 64, where s is the current signed step. Count 32 is the first clock after `td1` falls.
- R4: `phaseCode` is a 4-bit two's-complement step (0001 = +1, 1001 = -7). The single code 1000 means +8. After reset, s = +1, which puts the strobe at count 34.
- R5: `evalWindow` is high after reset. A clock edge with `evalReq` and `evalWindow` both high loads `phaseCode` into s, and the new step applies from the next clock. The same edge clears `evalWindow`, unless `wakeDone` is also high. An `evalReq` while `evalWindow` is low leaves s unchanged.
- R6: A rising edge of `driversOn` seen at clock edge E makes `presetPulse` high from edge E+2048 for exactly 1024 clocks.
- R7: Reset release (taken as edge 0), or `wakeDone` seen at edge E, makes `presetPulse` high from edge E+4144 for exactly 1024 clocks.
- R8: A new trigger ends any pending or running preload pulse and restarts the timing from that trigger. When `wakeDone` and a `driversOn` rise arrive on the same edge, the 4144-clock delay is used.
- R9: `wakeDone` sets `evalWindow` and does not change the current step s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 8 MHz) |
| rstN | input | 1 | Asynchronous active-low reset |
| wakeDone | input | 1 | One-clock pulse marking the end of a wake-up |
| driversOn | input | 1 | Antenna drivers enabled |
| evalReq | input | 1 | Request to load `phaseCode` as the new sample step |
| phaseCode | input | 4 | Signed sample step from the evaluation (1000 means +8) |
| td1 | output | 1 | Primary antenna drive level |
| td2 | output | 1 | Complementary antenna drive level |
| sampleStrobe | output | 1 | One-clock demodulator sample strobe |
| presetPulse | output | 1 | Hold-capacitor preload pulse |
| evalWindow | output | 1 | High while a new sample step may be loaded |

## Verification
The strobe position is tried with the reset default, both extreme codes (+8 and -7), and random codes. These cases separate a correct signed decode from one that treats 1000 as -8 or wraps the count wrongly. Evaluation requests are sent both inside and outside the window, and wake-ups are mixed in. This shows that a step is only taken while the window is open, and that a wake-up reopens the window without disturbing the step. Preload triggers come from reset, from driver rise, from wake-up, and from wake-up and driver rise on the same edge. Some triggers arrive while a pulse is pending or running. Together these cases distinguish the two start delays, the restart behaviour and the tie priority.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PULSE
  } presetState_t;

  // strobes issued by the control toward the datapath
  typedef struct packed {
    logic latchPhase;
    logic loadWake;
    logic loadDrv;
    logic loadLen;
  } cpgStrobes_t;

endpackage

// File: rtl/cpg_datapath.sv
module cpg_datapath
  import cpg_pkg::*;
#(
  parameter int HALF_CLKS   = 32,
  parameter int STEP_CLKS   = 2,
  parameter int CODE_W      = 4,
  parameter int PHASE_RESET = 1,
  parameter int DRV_DELAY   = 2048,
  parameter int WAKE_DELAY  = 4144,
  parameter int PRESET_LEN  = 1024,
  parameter int TIMER_W     = 13
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     driversOn,
  input  logic [CODE_W-1:0]        phaseCode,
  input  cpgStrobes_t              ctl,
  output logic                     td1,
  output logic                     td2,
  output logic                     sampleStrobe,
  output logic signed [CODE_W:0]   phaseStepQ,
  output logic                     timerDone
);

  localparam int PERIOD = 2 * HALF_CLKS;
  localparam int CNT_W  = $clog2(PERIOD);
  localparam int STEP_W = CODE_W + 1;
  localparam logic [CODE_W-1:0] MOST_NEG = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CNT_W-1:0]          carrierCnt;
  logic [CNT_W-1:0]          cntNext;
  logic signed [STEP_W-1:0]  stepVal;
  int                        tgtInt;
  logic [CNT_W-1:0]          targetCnt;
  logic [TIMER_W-1:0]        timerQ;

  // carrier counter: natural wrap for power-of-two periods
  generate
    if ((PERIOD & (PERIOD - 1)) == 0) begin : g_wrapPow2
      assign cntNext = carrierCnt + 1'b1;
    end else begin : g_wrapCmp
      assign cntNext = (carrierCnt == CNT_W'(PERIOD - 1)) ? '0 : carrierCnt + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) carrierCnt <= '0;
    else       carrierCnt <= cntNext;
  end

  // code decode: most negative pattern stands for the largest positive step
  always_comb begin
    if (phaseCode == MOST_NEG)
      stepVal = $signed({2'b01, {(CODE_W-1){1'b0}}});
    else
      stepVal = $signed({phaseCode[CODE_W-1], phaseCode});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               phaseStepQ <= STEP_W'(PHASE_RESET);
    else if (ctl.latchPhase) phaseStepQ <= stepVal;
  end

  // strobe target relative to the falling edge of td1 (count HALF_CLKS)
  always_comb begin
    tgtInt = HALF_CLKS + STEP_CLKS * int'(phaseStepQ);
    if (tgtInt < 0)            tgtInt = tgtInt + PERIOD;
    else if (tgtInt >= PERIOD) tgtInt = tgtInt - PERIOD;
  end
  assign targetCnt = tgtInt[CNT_W-1:0];

  assign td1          = driversOn && (carrierCnt < CNT_W'(HALF_CLKS));
  assign td2          = driversOn && (carrierCnt >= CNT_W'(HALF_CLKS));
  assign sampleStrobe = driversOn && (carrierCnt == targetCnt);

  // shared preload delay / length timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             timerQ <= TIMER_W'(WAKE_DELAY - 1);
    else if (ctl.loadWake) timerQ <= TIMER_W'(WAKE_DELAY - 1);
    else if (ctl.loadDrv)  timerQ <= TIMER_W'(DRV_DELAY - 1);
    else if (ctl.loadLen)  timerQ <= TIMER_W'(PRESET_LEN - 1);
    else if (timerQ != '0) timerQ <= timerQ - 1'b1;
  end
  assign timerDone = (timerQ == '0);

  AST_TD1_FALL_REF: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(td1) && driversOn && $past(driversOn)) |-> (carrierCnt == CNT_W'(HALF_CLKS))); // R1

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe); // R3

endmodule

// File: rtl/cpg_ctrl.sv
module cpg_ctrl
  import cpg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wakeDone,
  input  logic        driversOn,
  input  logic        evalReq,
  input  logic        timerDone,
  output cpgStrobes_t ctl,
  output logic        presetPulse,
  output logic        evalWindow
);

  presetState_t st, stNext;
  logic         driversOnQ;
  logic         drvRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) driversOnQ <= 1'b0;
    else       driversOnQ <= driversOn;
  end
  assign drvRise = driversOn && !driversOnQ;

  always_comb begin
    ctl            = '0;
    stNext         = st;
    ctl.latchPhase = evalReq && evalWindow;
    if (wakeDone) begin
      ctl.loadWake = 1'b1;
      stNext       = ST_WAIT;
    end else if (drvRise) begin
      ctl.loadDrv = 1'b1;
      stNext      = ST_WAIT;
    end else begin
      case (st)
        ST_WAIT: if (timerDone) begin
          ctl.loadLen = 1'b1;
          stNext      = ST_PULSE;
        end
        ST_PULSE: if (timerDone) stNext = ST_IDLE;
        default: ;
      endcase
    end
  end

  // reset behaves as a wake-class trigger
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_WAIT;
    else       st <= stNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               evalWindow <= 1'b1;
    else if (wakeDone)       evalWindow <= 1'b1;
    else if (ctl.latchPhase) evalWindow <= 1'b0;
  end

  assign presetPulse = (st == ST_PULSE);

  AST_WINDOW_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    (evalWindow && evalReq && !wakeDone) |=> !evalWindow); // R5

  AST_WAKE_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    wakeDone |=> evalWindow); // R9

  AST_PRESET_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(presetPulse) |-> ($past(st == ST_WAIT) && $past(timerDone))); // R6

  AST_TRIGGER_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (wakeDone || drvRise) |=> !presetPulse); // R8

endmodule

// File: rtl/carrier_phase_gen.sv
module carrier_phase_gen
  import cpg_pkg::*;
#(
  parameter int HALF_CLKS   = 32,
  parameter int STEP_CLKS   = 2,
  parameter int CODE_W      = 4,
  parameter int PHASE_RESET = 1,
  parameter int DRV_DELAY   = 2048,
  parameter int WAKE_DELAY  = 4144,
  parameter int PRESET_LEN  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wakeDone,
  input  logic              driversOn,
  input  logic              evalReq,
  input  logic [CODE_W-1:0] phaseCode,
  output logic              td1,
  output logic              td2,
  output logic              sampleStrobe,
  output logic              presetPulse,
  output logic              evalWindow
);

  localparam int MAX_DLY = (WAKE_DELAY > DRV_DELAY) ? WAKE_DELAY : DRV_DELAY;
  localparam int MAX_T   = (MAX_DLY > PRESET_LEN) ? MAX_DLY : PRESET_LEN;
  localparam int TIMER_W = $clog2(MAX_T + 1);

  cpgStrobes_t               ctl;
  logic                      timerDone;
  logic signed [CODE_W:0]    phaseStepQ;

  cpg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wakeDone    (wakeDone),
    .driversOn   (driversOn),
    .evalReq     (evalReq),
    .timerDone   (timerDone),
    .ctl         (ctl),
    .presetPulse (presetPulse),
    .evalWindow  (evalWindow)
  );

  cpg_datapath #(
    .HALF_CLKS   (HALF_CLKS),
    .STEP_CLKS   (STEP_CLKS),
    .CODE_W      (CODE_W),
    .PHASE_RESET (PHASE_RESET),
    .DRV_DELAY   (DRV_DELAY),
    .WAKE_DELAY  (WAKE_DELAY),
    .PRESET_LEN  (PRESET_LEN),
    .TIMER_W     (TIMER_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .driversOn    (driversOn),
    .phaseCode    (phaseCode),
    .ctl          (ctl),
    .td1          (td1),
    .td2          (td2),
    .sampleStrobe (sampleStrobe),
    .phaseStepQ   (phaseStepQ),
    .timerDone    (timerDone)
  );

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !evalWindow |=> $stable(phaseStepQ)); // R5

  AST_DRIVE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !driversOn |-> (!td1 && !td2 && !sampleStrobe)); // R2

endmodule

// File: tb/carrier_phase_gen_bench.sv
`timescale 1ns/1ps
module carrier_phase_gen_bench;

  localparam int PER  = 64;
  localparam int HALF = 32;
  localparam int DRV  = 2048;
  localparam int WAKE = 4144;
  localparam int LEN  = 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wakeDone = 1'b0;
  logic       driversOn = 1'b0;
  logic       evalReq = 1'b0;
  logic [3:0] phaseCode = 4'd0;
  logic       td1, td2, sampleStrobe, presetPulse, evalWindow;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit checkOn = 1'b0;

  // reference model state
  int edgeN, mPhase, lastTrig, trigDelay;
  bit mWin, prevDrv;

  always #2 clk = ~clk;

  carrier_phase_gen u_carrier_phase_gen (
    .clk(clk), .rstN(rstN), .wakeDone(wakeDone), .driversOn(driversOn),
    .evalReq(evalReq), .phaseCode(phaseCode), .td1(td1), .td2(td2),
    .sampleStrobe(sampleStrobe), .presetPulse(presetPulse), .evalWindow(evalWindow)
  );

  function automatic int decodeStep(logic [3:0] c);
    if (c == 4'b1000) return 8;
    if (c[3])         return int'(c) - 16;
    return int'(c);
  endfunction

  function automatic int strobePos(int s);
    return (((HALF + 2 * s) % PER) + PER) % PER;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", tag, act, exp, edgeN);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    bit latch;
    if (!rstN) begin
      edgeN = 0; mPhase = 1; mWin = 1'b1; lastTrig = 0; trigDelay = WAKE; prevDrv = 1'b0;
    end else begin
      edgeN++;
      latch = evalReq && mWin;
      if (latch) mPhase = decodeStep(phaseCode);
      if (wakeDone) mWin = 1'b1;
      else if (latch) mWin = 1'b0;
      if (wakeDone) begin lastTrig = edgeN; trigDelay = WAKE; end
      else if (driversOn && !prevDrv) begin lastTrig = edgeN; trigDelay = DRV; end
      prevDrv = driversOn;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && checkOn) begin
      int ph, d;
      bit eTd1, eTd2, eStb, ePre;
      ph   = edgeN % PER;
      eTd1 = driversOn && (ph < HALF);
      eTd2 = driversOn && (ph >= HALF);
      check({td1, td2} == {eTd1, eTd2}, driversOn ? "R1 drive levels" : "R2 drivers off",
            int'({td1, td2}), int'({eTd1, eTd2}));
      eStb = driversOn && (ph == strobePos(mPhase));
      check(sampleStrobe == eStb, "R3 strobe", int'(sampleStrobe), int'(eStb));
      check(evalWindow == mWin, "R5 window", int'(evalWindow), int'(mWin));
      d    = edgeN - lastTrig;
      ePre = (d >= trigDelay) && (d < trigDelay + LEN);
      check(presetPulse == ePre, (trigDelay == DRV) ? "R6 preset" : "R7 preset",
            int'(presetPulse), int'(ePre));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
      finishRun();
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic pulseEval(logic [3:0] c);
    step(); evalReq = 1'b1; phaseCode = c;
    step(); evalReq = 1'b0;
  endtask

  task automatic pulseWake();
    step(); wakeDone = 1'b1;
    step(); wakeDone = 1'b0;
  endtask

  task automatic waitStrobe(output int pos);
    pos = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sampleStrobe) begin pos = edgeN % PER; break; end
    end
    #1;
  endtask

  // waits for preset rise; returns edges since given trigger edge
  task automatic waitPreset(int trig, output int dly);
    dly = -1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (presetPulse) begin dly = edgeN - trig; break; end
    end
    #1;
  endtask

  initial begin
    int pos, dly, trig;
    void'($urandom(32'd20240611));
    idle(3);
    rstN = 1'b1;
    checkOn = 1'b1;
    @(negedge clk);
    check(!td1 && !td2 && !sampleStrobe, "R2 reset outputs", int'({td1, td2, sampleStrobe}), 0);
    check(evalWindow && !presetPulse, "R5 reset window", int'({evalWindow, presetPulse}), 2);
    #1;
    idle(100);

    // drivers on during pending reset preload: restart with the shorter delay
    step(); driversOn = 1'b1; trig = edgeN + 1;
    waitStrobe(pos);
    check(pos == 34, "R4 default step +1", pos, 34);
    waitPreset(trig, dly);
    check(dly == DRV, "R8 restart on driver rise", dly, DRV);

    pulseEval(4'b1000);
    waitStrobe(pos); waitStrobe(pos);
    check(pos == 48, "R4 code 1000 is +8", pos, 48);
    check(!evalWindow, "R5 window closed", int'(evalWindow), 0);

    pulseEval(4'b1001);
    waitStrobe(pos); waitStrobe(pos);
    check(pos == 48, "R5 request outside window ignored", pos, 48);

    pulseWake();
    waitStrobe(pos); waitStrobe(pos);
    check(pos == 48, "R9 wake keeps step", pos, 48);
    check(evalWindow, "R9 wake opens window", int'(evalWindow), 1);

    pulseEval(4'b1001);
    waitStrobe(pos); waitStrobe(pos);
    check(pos == 18, "R4 code 1001 is -7", pos, 18);
    idle(5400);

    // simultaneous wake and driver rise: wake delay wins
    step(); driversOn = 1'b0;
    step(); driversOn = 1'b1; wakeDone = 1'b1; trig = edgeN + 1;
    step(); wakeDone = 1'b0;
    waitPreset(trig, dly);
    check(dly == WAKE, "R8 tie uses wake delay", dly, WAKE);
    idle(LEN + 10);

    // constrained random traffic
    for (int k = 0; k < 40; k++) begin
      int sel;
      sel = $urandom_range(0, 4);
      case (sel)
        0: begin step(); driversOn = ~driversOn; end
        1: pulseWake();
        2: pulseEval(4'($urandom_range(0, 15)));
        3: begin step(); wakeDone = 1'b1; evalReq = 1'b1; phaseCode = 4'($urandom_range(0, 15));
                 step(); wakeDone = 1'b0; evalReq = 1'b0; end
        default: ;
      endcase
      idle($urandom_range(1, 1500));
    end
    step(); driversOn = 1'b1;
    idle(WAKE + LEN + 10);
    finishRun();
  end

endmodule